// File: doc/BRIEF.md
# Piecewise-Linear Calibration Converter

This block turns a 12-bit raw code from an on-die thermal sensor into a signed temperature in millidegrees Celsius. It uses a calibration table of (raw code, temperature) pairs held in its own registers. A write port loads the table, and a separate count register says how many entries are valid. After loading, a one-cycle `start` pulse with a code on `raw_in` begins a conversion. The block answers with a one-cycle `done` pulse and holds the result on `temp_out` until the next answer.

A conversion first works out the table's direction from its first two raw codes. It then clamps codes that lie outside the table and walks the table one entry per cycle. A code equal to an interior entry's raw code returns that entry's temperature directly. Any other code is interpolated linearly between the two neighbouring entries. The interpolation uses a restoring divider that works on magnitudes, and the quotient's sign is applied afterwards, so the division truncates toward zero. Typical tables step by 5000 m°C from -40000 to 125000, and their raw codes can run either upward or downward.

Top module: `cal_lut_conv`

## Requirements
- R1: After reset, `busy`, `done` and `temp_out` are all zero, and the entry count is 2.
- R2: Writing with `tbl_wr` high stores `tbl_raw`/`tbl_temp` into entry `tbl_addr` (0 to 35). A write to a higher address changes nothing.
- R3: The table is treated as descending when the raw code of entry 0 is strictly greater than that of entry 1, and as ascending otherwise (including when the two are equal).
- R4: Ascending table: a code at or below entry 0's raw code returns entry 0's temperature, and a code at or above the last valid entry's raw code returns that entry's temperature.
- R5: Descending table: a code at or above entry 0's raw code returns entry 0's temperature, and a code at or below the last valid entry's raw code returns that entry's temperature.
- R6: A code equal to the raw code of an interior entry returns that entry's temperature exactly.
- R7: Any other code lies between adjacent entries k and k+1 and returns T[k] + ((T[k]-T[k+1])*(code-R[k])) / (R[k]-R[k+1]). The arithmetic is signed and the division truncates toward zero. The divider takes exactly 32 cycles from launch to result.
- R8: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is high is ignored: it gives no extra `done` and does not change the result.
- R9: `done` is a single-cycle pulse, and `temp_out` changes only in a cycle where `done` is high.
- R10: A write through `cnt_wr` sets the number of valid entries, clamped to the range 2 to 36. Entries at or beyond that count take no part in a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_addr | input | 6 | Entry index to write |
| tbl_raw | input | 12 | Raw code of the entry |
| tbl_temp | input | 32 | Signed temperature of the entry (m°C) |
| cnt_wr | input | 1 | Entry count write strobe |
| cnt_val | input | 6 | Requested entry count (clamped 2..36) |
| start | input | 1 | Conversion start pulse |
| raw_in | input | 12 | Raw code to convert, sampled with `start` |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result pulse |
| temp_out | output | 32 | Signed converted temperature (m°C) |

## Verification
The hardest case to reach from the ports is a quotient whose exact value is negative and not a whole number, where truncation and flooring give different answers. Real calibration tables never produce one, because raw code and temperature move in step. The bench therefore loads a short hand-made table in which temperature falls as the raw code rises, with gaps chosen so the quotient leaves a remainder. It also loads a table whose first two raw codes are equal, to show that an equal pair is taken as ascending. Separate runs shrink and stretch the entry count so that loaded entries past the count are shown to be ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    CV_IDLE,
    CV_BOUNDS,
    CV_SCAN,
    CV_PREP,
    CV_DIV
  } conv_state_e;

endpackage

// File: rtl/cal_table.sv
module cal_table #(
  parameter int RAW_W   = 12,
  parameter int TEMP_W  = 32,
  parameter int ENTRIES = 36,
  parameter int IDX_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_addr,
  input  logic [RAW_W-1:0]         wr_raw,
  input  logic signed [TEMP_W-1:0] wr_temp,
  input  logic                     cnt_en,
  input  logic [IDX_W-1:0]         cnt_in,
  input  logic [IDX_W-1:0]         a_idx,
  input  logic [IDX_W-1:0]         b_idx,
  output logic [RAW_W-1:0]         a_raw,
  output logic signed [TEMP_W-1:0] a_temp,
  output logic [RAW_W-1:0]         b_raw,
  output logic signed [TEMP_W-1:0] b_temp,
  output logic [RAW_W-1:0]         first_raw,
  output logic signed [TEMP_W-1:0] first_temp,
  output logic [RAW_W-1:0]         second_raw,
  output logic [RAW_W-1:0]         last_raw,
  output logic signed [TEMP_W-1:0] last_temp,
  output logic [IDX_W-1:0]         count
);

  localparam logic [IDX_W-1:0] MIN_CNT = IDX_W'(2);
  localparam logic [IDX_W-1:0] MAX_CNT = IDX_W'(ENTRIES);

  logic [RAW_W-1:0]         raw_q  [ENTRIES];
  logic signed [TEMP_W-1:0] temp_q [ENTRIES];
  logic [IDX_W-1:0]         cnt_q, cnt_d;
  logic [IDX_W-1:0]         last_idx;

  // one register pair per entry, each with its own write enable
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[g]  <= '0;
        temp_q[g] <= '0;
      end else if (hit) begin
        raw_q[g]  <= wr_raw;
        temp_q[g] <= wr_temp;
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (cnt_in < MIN_CNT)      cnt_d = MIN_CNT;
      else if (cnt_in > MAX_CNT) cnt_d = MAX_CNT;
      else                       cnt_d = cnt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= MIN_CNT;
    else        cnt_q <= cnt_d;
  end

  assign last_idx = cnt_q - IDX_W'(1);
  assign count    = cnt_q;

  always_comb begin
    a_raw  = '0;
    a_temp = '0;
    b_raw  = '0;
    b_temp = '0;
    last_raw  = '0;
    last_temp = '0;
    if (a_idx < MAX_CNT) begin
      a_raw  = raw_q[a_idx];
      a_temp = temp_q[a_idx];
    end
    if (b_idx < MAX_CNT) begin
      b_raw  = raw_q[b_idx];
      b_temp = temp_q[b_idx];
    end
    if (last_idx < MAX_CNT) begin
      last_raw  = raw_q[last_idx];
      last_temp = temp_q[last_idx];
    end
  end

  assign first_raw  = raw_q[0];
  assign first_temp = temp_q[0];
  assign second_raw = raw_q[1];

endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int N_W = 32,
  parameter int D_W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [N_W-1:0] quot
);

  localparam int C_W = $clog2(N_W + 1);

  logic [D_W-1:0] rem_q, rem_d;
  logic [N_W-1:0] quo_q, quo_d;
  logic [D_W-1:0] den_q, den_d;
  logic [C_W-1:0] cnt_q, cnt_d;
  logic           done_q, done_d;
  logic [D_W:0]   trial;
  logic           fits;

  always_comb begin
    trial  = {rem_q, quo_q[N_W-1]};
    fits   = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = C_W'(N_W);
    end else if (cnt_q != '0) begin
      rem_d  = fits ? D_W'(trial - {1'b0, den_q}) : trial[D_W-1:0];
      quo_d  = {quo_q[N_W-2:0], fits};
      cnt_d  = cnt_q - C_W'(1);
      done_d = (cnt_q == C_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = quo_q;

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int TEMP_W = 32,
  parameter int IDX_W  = 6,
  parameter int DIV_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [RAW_W-1:0]         raw_in,
  input  logic [IDX_W-1:0]         count,
  input  logic [RAW_W-1:0]         first_raw,
  input  logic signed [TEMP_W-1:0] first_temp,
  input  logic [RAW_W-1:0]         second_raw,
  input  logic [RAW_W-1:0]         last_raw,
  input  logic signed [TEMP_W-1:0] last_temp,
  input  logic [RAW_W-1:0]         a_raw,
  input  logic signed [TEMP_W-1:0] a_temp,
  input  logic [RAW_W-1:0]         b_raw,
  input  logic signed [TEMP_W-1:0] b_temp,
  output logic [IDX_W-1:0]         a_idx,
  output logic [IDX_W-1:0]         b_idx,
  output logic                     div_go,
  output logic [DIV_W-1:0]         div_num,
  output logic [RAW_W:0]           div_den,
  input  logic                     div_done,
  input  logic [DIV_W-1:0]         div_quot,
  output logic                     busy,
  output logic                     done,
  output logic signed [TEMP_W-1:0] temp_out
);

  conv_state_e              state_q, state_d;
  logic [RAW_W-1:0]         code_q, code_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic                     desc_q, desc_d;
  logic signed [TEMP_W-1:0] anchor_q, anchor_d;
  logic                     neg_q, neg_d;
  logic                     done_q, done_d;
  logic signed [TEMP_W-1:0] res_q, res_d;

  logic                     desc_now;
  logic signed [TEMP_W-1:0] d_temp;
  logic signed [RAW_W:0]    d_code;
  logic signed [RAW_W:0]    d_raw;
  logic signed [DIV_W-1:0]  prod;
  logic signed [TEMP_W-1:0] q_signed;

  assign a_idx = idx_q;
  assign b_idx = idx_q + IDX_W'(1);

  always_comb begin
    desc_now = (first_raw > second_raw);
    d_temp   = a_temp - b_temp;
    d_code   = $signed({1'b0, code_q}) - $signed({1'b0, a_raw});
    d_raw    = $signed({1'b0, a_raw}) - $signed({1'b0, b_raw});
    prod     = DIV_W'(d_temp) * DIV_W'(d_code);
    div_num  = prod[DIV_W-1] ? DIV_W'(-prod) : DIV_W'(prod);
    div_den  = d_raw[RAW_W] ? RAW_W'(-d_raw) + (RAW_W+1)'(0) : d_raw;
    q_signed = $signed(TEMP_W'(div_quot));
  end

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    idx_d    = idx_q;
    desc_d   = desc_q;
    anchor_d = anchor_q;
    neg_d    = neg_q;
    done_d   = 1'b0;
    res_d    = res_q;
    div_go   = 1'b0;
    unique case (state_q)
      CV_IDLE: begin
        if (start) begin
          code_d  = raw_in;
          state_d = CV_BOUNDS;
        end
      end
      CV_BOUNDS: begin
        desc_d = desc_now;
        if ((!desc_now && code_q <= first_raw) || (desc_now && code_q >= first_raw)) begin
          res_d   = first_temp;
          done_d  = 1'b1;
          state_d = CV_IDLE;
        end else if ((!desc_now && code_q >= last_raw) || (desc_now && code_q <= last_raw)) begin
          res_d   = last_temp;
          done_d  = 1'b1;
          state_d = CV_IDLE;
        end else begin
          idx_d   = desc_now ? count - IDX_W'(2) : IDX_W'(1);
          state_d = CV_SCAN;
        end
      end
      CV_SCAN: begin
        if (code_q == a_raw) begin
          res_d   = a_temp;
          done_d  = 1'b1;
          state_d = CV_IDLE;
        end else if (code_q < a_raw) begin
          // bracket found: anchor is the lower-index entry of the pair
          idx_d   = desc_q ? idx_q : idx_q - IDX_W'(1);
          state_d = CV_PREP;
        end else begin
          idx_d = desc_q ? idx_q - IDX_W'(1) : idx_q + IDX_W'(1);
        end
      end
      CV_PREP: begin
        div_go   = 1'b1;
        anchor_d = a_temp;
        neg_d    = prod[DIV_W-1] ^ d_raw[RAW_W];
        state_d  = CV_DIV;
      end
      CV_DIV: begin
        if (div_done) begin
          res_d   = anchor_q + (neg_q ? -q_signed : q_signed);
          done_d  = 1'b1;
          state_d = CV_IDLE;
        end
      end
      default: state_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CV_IDLE;
      code_q   <= '0;
      idx_q    <= '0;
      desc_q   <= 1'b0;
      anchor_q <= '0;
      neg_q    <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_d;
      idx_q    <= idx_d;
      desc_q   <= desc_d;
      anchor_q <= anchor_d;
      neg_q    <= neg_d;
      done_q   <= done_d;
      res_q    <= res_d;
    end
  end

  assign busy     = (state_q != CV_IDLE);
  assign done     = done_q;
  assign temp_out = res_q;

endmodule

// File: rtl/cal_lut_conv.sv
module cal_lut_conv #(
  parameter int RAW_W   = 12,
  parameter int TEMP_W  = 32,
  parameter int ENTRIES = 36,
  parameter int DIV_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_wr,
  input  logic [IDX_W-1:0]         tbl_addr,
  input  logic [RAW_W-1:0]         tbl_raw,
  input  logic signed [TEMP_W-1:0] tbl_temp,
  input  logic                     cnt_wr,
  input  logic [IDX_W-1:0]         cnt_val,
  input  logic                     start,
  input  logic [RAW_W-1:0]         raw_in,
  output logic                     busy,
  output logic                     done,
  output logic signed [TEMP_W-1:0] temp_out
);

  logic [IDX_W-1:0]         a_idx, b_idx, entry_count;
  logic [RAW_W-1:0]         a_raw, b_raw, first_raw, second_raw, last_raw;
  logic signed [TEMP_W-1:0] a_temp, b_temp, first_temp, last_temp;
  logic                     div_go, div_done;
  logic [DIV_W-1:0]         div_num, div_quot;
  logic [RAW_W:0]           div_den;

  cal_table #(
    .RAW_W(RAW_W), .TEMP_W(TEMP_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_addr(tbl_addr), .wr_raw(tbl_raw), .wr_temp(tbl_temp),
    .cnt_en(cnt_wr), .cnt_in(cnt_val),
    .a_idx(a_idx), .b_idx(b_idx),
    .a_raw(a_raw), .a_temp(a_temp), .b_raw(b_raw), .b_temp(b_temp),
    .first_raw(first_raw), .first_temp(first_temp), .second_raw(second_raw),
    .last_raw(last_raw), .last_temp(last_temp), .count(entry_count)
  );

  cal_divider #(.N_W(DIV_W), .D_W(RAW_W + 1)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quot(div_quot)
  );

  cal_ctrl #(
    .RAW_W(RAW_W), .TEMP_W(TEMP_W), .IDX_W(IDX_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_in(raw_in), .count(entry_count),
    .first_raw(first_raw), .first_temp(first_temp), .second_raw(second_raw),
    .last_raw(last_raw), .last_temp(last_temp),
    .a_raw(a_raw), .a_temp(a_temp), .b_raw(b_raw), .b_temp(b_temp),
    .a_idx(a_idx), .b_idx(b_idx),
    .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quot(div_quot),
    .busy(busy), .done(done), .temp_out(temp_out)
  );

endmodule

// File: rtl/cal_lut_conv_chk.sv
module cal_lut_conv_chk #(
  parameter int TEMP_W  = 32,
  parameter int ENTRIES = 36,
  parameter int DIV_W   = 32,
  parameter int IDX_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic signed [TEMP_W-1:0] temp_out,
  input logic [IDX_W-1:0]         entry_count,
  input logic                     div_go,
  input logic                     div_done
);

  int gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= 0;
    else if (div_go) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  assert_div_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (gap_q == DIV_W));

  assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(temp_out) |-> done);

  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_count >= IDX_W'(2)) && (entry_count <= IDX_W'(ENTRIES)));

endmodule

bind cal_lut_conv cal_lut_conv_chk #(
  .TEMP_W(TEMP_W), .ENTRIES(ENTRIES), .DIV_W(DIV_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .temp_out(temp_out), .entry_count(entry_count),
  .div_go(div_go), .div_done(div_done)
);

// File: tb/tb_cal_lut_conv.sv
module tb_cal_lut_conv;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr;
  logic [5:0]  tbl_addr;
  logic [11:0] tbl_raw;
  logic signed [31:0] tbl_temp;
  logic        cnt_wr;
  logic [5:0]  cnt_val;
  logic        start;
  logic [11:0] raw_in;
  logic        busy, done;
  logic signed [31:0] temp_out;

  int checks = 0;
  int fails  = 0;
  int m_r[36];
  int m_t[36];
  int m_n;

  always #2.5 clk = ~clk;

  cal_lut_conv dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .tbl_raw(tbl_raw), .tbl_temp(tbl_temp), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .start(start), .raw_in(raw_in), .busy(busy), .done(done), .temp_out(temp_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int code);
    bit desc;
    int last;
    desc = m_r[0] > m_r[1];
    last = m_n - 1;
    if (!desc) begin
      if (code <= m_r[0]) return m_t[0];
      if (code >= m_r[last]) return m_t[last];
    end else begin
      if (code >= m_r[0]) return m_t[0];
      if (code <= m_r[last]) return m_t[last];
    end
    for (int k = 1; k < last; k++)
      if (code == m_r[k]) return m_t[k];
    for (int k = 0; k < last; k++)
      if ((code > m_r[k] && code < m_r[k+1]) || (code < m_r[k] && code > m_r[k+1]))
        return m_t[k] + ((m_t[k] - m_t[k+1]) * (code - m_r[k])) / (m_r[k] - m_r[k+1]);
    return 0;
  endfunction

  task automatic put(input int idx, input int r, input int t);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_addr = 6'(idx); tbl_raw = 12'(r); tbl_temp = t;
    @(negedge clk);
    tbl_wr = 1'b0;
    if (idx < 36) begin m_r[idx] = r; m_t[idx] = t; end
  endtask

  task automatic set_count(input int v);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_val = 6'(v);
    @(negedge clk);
    cnt_wr = 1'b0;
    m_n = (v < 2) ? 2 : (v > 36) ? 36 : v;
  endtask

  task automatic convert(input int code, output int res);
    int wait_n;
    @(negedge clk);
    start = 1'b1; raw_in = 12'(code);
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    if (!done) chk(1'b0, "R8 timeout", wait_n, 200);
    res = temp_out;
  endtask

  task automatic expect_conv(input int code, input string req);
    int res;
    convert(code, res);
    chk(res == model(code), req, res, model(code));
  endtask

  task automatic load_asc(input int n);
    for (int k = 0; k < n; k++) put(k, 296 + 9*k + (k*k)/4, -40000 + 5000*k);
  endtask

  task automatic load_desc(input int n);
    for (int k = 0; k < n; k++) put(k, 3800 - 9*k - (k*k)/8, -40000 + 5000*k);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(temp_out == 0, "R1 temp_out", temp_out, 0);
    // count is 2 after reset: entries 0 and 1 only
    put(0, 100, 7000); put(1, 200, 9000); put(2, 300, 55555);
    m_n = 2;
    expect_conv(250, "R1 reset count 2");
  endtask

  task automatic t_ascending;
    load_asc(34); set_count(34);
    expect_conv(m_r[0] - 5, "R4 below first");
    expect_conv(m_r[0], "R4 at first");
    expect_conv(m_r[33] + 3, "R4 above last");
    expect_conv(m_r[33], "R4 at last");
    expect_conv(m_r[10], "R6 exact asc");
    expect_conv(m_r[3] + 1, "R7 asc interp low");
    expect_conv(m_r[20] + 4, "R7 asc interp mid");
    expect_conv(m_r[32] + 1, "R7 asc interp top");
  endtask

  task automatic t_descending;
    load_desc(34); set_count(34);
    expect_conv(m_r[0] + 7, "R5 above first");
    expect_conv(m_r[0], "R5 at first");
    expect_conv(m_r[33] - 2, "R5 below last");
    expect_conv(m_r[33], "R5 at last");
    expect_conv(m_r[17], "R6 exact desc");
    expect_conv(m_r[1] + 3, "R3 desc interp near top");
    expect_conv(m_r[25] - 5, "R7 desc interp mid");
    expect_conv(m_r[32] - 1, "R7 desc interp end");
  endtask

  task automatic t_equal_pair;
    put(0, 100, 50000); put(1, 100, 1000); put(2, 200, 3000); set_count(3);
    expect_conv(150, "R3 equal pair ascending");
  endtask

  task automatic t_trunc;
    put(0, 100, 1000); put(1, 103, 0); put(2, 110, -705); set_count(3);
    expect_conv(101, "R7 trunc neg quotient 1");
    expect_conv(102, "R7 trunc neg quotient 2");
    expect_conv(104, "R7 trunc neg quotient 3");
    expect_conv(108, "R7 trunc neg quotient 4");
  endtask

  task automatic t_count;
    load_asc(36); put(40, 5, 99999);
    set_count(63);
    expect_conv(m_r[35] + 1, "R10 count saturates high");
    expect_conv(m_r[34] + 2, "R10 top entries usable");
    expect_conv(m_r[0] - 1, "R2 high address write ignored");
    set_count(5);
    expect_conv(m_r[20], "R10 entries past count ignored");
    set_count(0);
    expect_conv(2000, "R10 count saturates low");
    expect_conv(m_r[0] + 4, "R10 two-entry interp");
  endtask

  task automatic t_busy;
    int res, extra, first;
    load_asc(34); set_count(34);
    first = m_r[12] + 2;
    @(negedge clk);
    start = 1'b1; raw_in = 12'(first);
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    raw_in = 12'(m_r[0]);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    res = temp_out;
    chk(res == model(first), "R8 start while busy ignored", res, model(first));
    chk(busy == 1'b0, "R8 busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single pulse", done, 0);
    extra = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) extra++;
      if (temp_out != res) extra++;
    end
    chk(extra == 0, "R9 no second done, output held", extra, 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; tbl_wr = 1'b0; tbl_addr = '0; tbl_raw = '0; tbl_temp = '0;
    cnt_wr = 1'b0; cnt_val = '0; start = 1'b0; raw_in = '0;
    m_n = 2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ascending;
    t_descending;
    t_equal_pair;
    t_trunc;
    t_count;
    t_busy;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule